// File: doc/BRIEF.md
# Shared Bus Tenure Arbiter

This block decides which of several masters may drive a shared data bus, and for how long. Each master raises a request and names the kind of transfer it wants: one byte, one word, or a whole line. A byte or word transfer holds the bus for a single beat. A line transfer holds it for `LINE_BEATS` beats. Once a tenure starts it always runs to its full length, and the bus passes on only at a tenure boundary. Masters that are waiting are served in rotating order, beginning with the master after the most recent owner.

A mode input chooses how one tenure hands over to the next. In spaced mode the bus is idle for exactly one cycle after every tenure. In streaming mode a new tenure can begin on the cycle right after the previous one ends. An owner that keeps requesting therefore streams back-to-back lines with no gap, until some other master asks for the bus. The outputs are a one-hot grant vector, a beat counter within the current tenure, and a pulse on the last beat of each tenure. The data path and the memory timing sit outside this block.

Top module: `tenure_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `grant` is zero, `beat_cnt` is zero and `tenure_end` is low.
- R2: `grant` is either all zero or one-hot. A new tenure is granted only to a master whose `req` bit was high on the clock edge that started the tenure, so the grant appears one cycle after the request is sampled.
- R3: The tenure length comes from the winner's `req_kind`. The encoding is 2'b00 for byte (1 beat), 2'b01 for word (1 beat), 2'b10 for line (`LINE_BEATS` beats, 4 by default) and 2'b11 (reserved) for a word (1 beat).
- R4: `beat_cnt` is 0 on the first beat of every tenure and rises by one on each following beat. `tenure_end` is high only on the final beat, and only while a grant is active.
- R5: The grant stays on the same master for the whole tenure, even if that master drops its request or other masters raise theirs.
- R6: In spaced mode (`stream_mode`=0), `grant` is zero for exactly one cycle after every tenure ends, before any new tenure starts.
- R7: In streaming mode (`stream_mode`=1), if any master requests on a tenure's final beat, the next tenure starts on the very next cycle. The current owner gets a back-to-back tenure only if no other master is requesting.
- R8: Among requesting masters, the winner is the first one found when counting upward (with wrap-around) from the master after the last owner. After reset, master 0 has first priority.
- R9: When no tenure is running and no master requests, `grant` stays zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stream_mode | input | 1 | 1 = back-to-back tenures allowed, 0 = one idle cycle between tenures |
| req | input | N | Request bit per master |
| req_kind | input | N x 2 | Transfer kind per master (00 byte, 01 word, 10 line, 11 word) |
| grant | output | N | One-hot bus grant, zero when the bus is idle |
| beat_cnt | output | clog2(LINE_BEATS) | Beat index within the current tenure |
| tenure_end | output | 1 | High on the final beat of a tenure |

## Verification
A request sampled at a clock edge while the bus is free shows up as a grant with `beat_cnt`=0 in the cycle that edge starts. Each later beat follows one cycle after the one before. The idle gap in spaced mode is the single cycle after the one in which `tenure_end` is high. In streaming mode the next owner appears in that same cycle. The bench drives inputs and samples outputs on the falling edge. It counts cycles from the first granted cycle and derives the expected grant, beat and end pulse arithmetically from the tenure length and the mode, so every comparison falls a fixed, known number of registers after its stimulus.

// File: rtl/tenure_arb_pkg.sv
package tenure_arb_pkg;

    typedef enum logic [1:0] {
        KIND_BYTE = 2'b00,
        KIND_WORD = 2'b01,
        KIND_LINE = 2'b10,
        KIND_RSVD = 2'b11
    } xfer_kind_e;

    // Number of beats a tenure of the given kind occupies.
    function automatic int unsigned kind_beats(input logic [1:0] kind,
                                               input int unsigned line_beats);
        if (kind == KIND_LINE) return line_beats;
        return 1;
    endfunction

endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          hit,
    output logic [IW-1:0] idx
);

    // Scan from last+1 upward with wrap; the last owner is scanned last.
    always_comb begin
        hit = 1'b0;
        idx = last;
        for (int i = 1; i <= N; i++) begin
            if (!hit && req[(int'(last) + i) % N]) begin
                hit = 1'b1;
                idx = IW'((int'(last) + i) % N);
            end
        end
    end

endmodule

// File: rtl/tenure_arbiter.sv
module tenure_arbiter
    import tenure_arb_pkg::*;
#(
    parameter int N          = 4,
    parameter int LINE_BEATS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stream_mode,
    input  logic [N-1:0]          req,
    input  logic [N-1:0][1:0]     req_kind,
    output logic [N-1:0]          grant,
    output logic [((LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1)-1:0] beat_cnt,
    output logic                  tenure_end
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] owner;
        logic [CW-1:0] beat;
        logic [CW-1:0] final_beat;
    } arb_state_t;

    arb_state_t st_q, st_d;

    logic          win_hit;
    logic [IW-1:0] win_idx;
    logic          at_final;
    logic          may_start;

    rr_picker #(.N(N), .IW(IW)) u_pick (
        .req  (req),
        .last (st_q.owner),
        .hit  (win_hit),
        .idx  (win_idx)
    );

    assign at_final = st_q.busy && (st_q.beat == st_q.final_beat);

    always_comb begin
        st_d      = st_q;
        may_start = 1'b0;
        if (st_q.busy && !at_final) begin
            st_d.beat = st_q.beat + CW'(1);
        end else begin
            // Idle cycle, or final beat with back-to-back handover allowed.
            may_start  = !st_q.busy || stream_mode;
            st_d.busy  = 1'b0;
            st_d.beat  = '0;
            if (may_start && win_hit) begin
                st_d.busy       = 1'b1;
                st_d.owner      = win_idx;
                st_d.final_beat = CW'(kind_beats(req_kind[win_idx], LINE_BEATS) - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy       <= 1'b0;
            st_q.owner      <= IW'(N - 1);
            st_q.beat       <= '0;
            st_q.final_beat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_grant
        assign grant[g] = st_q.busy && (st_q.owner == IW'(g));
    end

    assign beat_cnt   = st_q.beat;
    assign tenure_end = at_final;

endmodule

// File: rtl/tenure_arbiter_chk.sv
module tenure_arbiter_chk #(
    parameter int N          = 4,
    parameter int LINE_BEATS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  stream_mode,
    input logic [N-1:0]          req,
    input logic [N-1:0]          grant,
    input logic [((LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1)-1:0] beat_cnt,
    input logic                  tenure_end
);

    localparam int CW = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2
    grant_had_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && beat_cnt == '0) |-> (($past(req) & grant) != '0));

    // R4 R5
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !tenure_end) |=>
            (grant == $past(grant) && beat_cnt == $past(beat_cnt) + CW'(1)));

    // R4
    end_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tenure_end |-> (grant != '0));

    // R6
    spaced_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tenure_end && !stream_mode) |=> (grant == '0));

    // R7
    stream_nogap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tenure_end && stream_mode && req != '0) |=> (grant != '0));

    // R9
    stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && req == '0) |=> (grant == '0));

endmodule

bind tenure_arbiter tenure_arbiter_chk #(.N(N), .LINE_BEATS(LINE_BEATS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stream_mode (stream_mode),
    .req         (req),
    .grant       (grant),
    .beat_cnt    (beat_cnt),
    .tenure_end  (tenure_end)
);

// File: tb/tenure_arbiter_bench.sv
module tenure_arbiter_bench;

    localparam int N          = 4;
    localparam int LINE_BEATS = 4;
    localparam int CW         = 2;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              stream_mode;
    logic [N-1:0]      req;
    logic [N-1:0][1:0] req_kind;
    logic [N-1:0]      grant;
    logic [CW-1:0]     beat_cnt;
    logic              tenure_end;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tenure_arbiter #(.N(N), .LINE_BEATS(LINE_BEATS)) u_tenure_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .stream_mode (stream_mode),
        .req         (req),
        .req_kind    (req_kind),
        .grant       (grant),
        .beat_cnt    (beat_cnt),
        .tenure_end  (tenure_end)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Compare all three outputs against the expected values for this cycle.
    task automatic chk_cycle(input string tag, input int g, input int b, input int e);
        chk({tag, " grant"}, int'(grant), g);
        chk({tag, " beat"}, int'(beat_cnt), b);
        chk({tag, " end"}, int'(tenure_end), e);
    endtask

    task automatic do_reset(input logic mode);
        rst_n       = 1'b0;
        req         = '0;
        req_kind    = '0;
        stream_mode = mode;
        repeat (2) @(negedge clk);
        chk_cycle("R1 in reset", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_cycle("R1 after reset", 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        // Single-master sweep: R3 R4 R6 R7 R9 over every mode, master and kind.
        for (int mode = 0; mode < 2; mode++) begin
            for (int m = 0; m < N; m++) begin
                for (int k = 0; k < 4; k++) begin
                    int len;
                    int per;
                    len = (k == 2) ? LINE_BEATS : 1;
                    per = (mode == 1) ? len : len + 1;
                    do_reset(logic'(mode));
                    req_kind[m] = 2'(k);
                    req[m]      = 1'b1;
                    for (int t = 0; t < 12; t++) begin
                        int ph;
                        @(negedge clk);
                        ph = t % per;
                        if (ph < len)
                            chk_cycle($sformatf("R3 R4 R6 R7 mode%0d m%0d k%0d t%0d", mode, m, k, t),
                                      1 << m, ph, (ph == len - 1) ? 1 : 0);
                        else
                            chk_cycle($sformatf("R6 gap m%0d k%0d t%0d", m, k, t), 0, 0, 0);
                    end
                    req[m] = 1'b0;
                    repeat (LINE_BEATS + 2) @(negedge clk);
                    chk_cycle($sformatf("R9 idle mode%0d m%0d k%0d", mode, m, k), 0, 0, 0);
                end
            end
        end

        // R5: request dropped right after a line starts; tenure still completes.
        do_reset(1'b1);
        req_kind[2] = 2'b10;
        req[2]      = 1'b1;
        @(negedge clk);
        chk_cycle("R5 t0", 1 << 2, 0, 0);
        req[2] = 1'b0;
        for (int t = 1; t < LINE_BEATS; t++) begin
            @(negedge clk);
            chk_cycle($sformatf("R5 t%0d", t), 1 << 2, t, (t == LINE_BEATS - 1) ? 1 : 0);
        end
        @(negedge clk);
        chk_cycle("R5 R9 release", 0, 0, 0);

        // R5 R7 R6 R8: competing line request mid-tenure, both modes.
        for (int mode = 0; mode < 2; mode++) begin
            int gap;
            int t3;
            int t1b;
            gap = (mode == 1) ? 0 : 1;
            do_reset(logic'(mode));
            req_kind    = '0;
            req_kind[1] = 2'b10;
            req_kind[3] = 2'b10;
            req[1]      = 1'b1;
            @(negedge clk);
            chk_cycle($sformatf("R5 contend mode%0d m1 t0", mode), 1 << 1, 0, 0);
            req[3] = 1'b1;
            t3  = LINE_BEATS + gap;
            t1b = t3 + LINE_BEATS + gap;
            for (int t = 1; t <= t1b; t++) begin
                @(negedge clk);
                if (t < LINE_BEATS)
                    chk_cycle($sformatf("R5 mode%0d m1 t%0d", mode, t), 1 << 1, t,
                              (t == LINE_BEATS - 1) ? 1 : 0);
                else if (t < t3)
                    chk_cycle($sformatf("R6 mode%0d gap t%0d", mode, t), 0, 0, 0);
                else if (t < t3 + LINE_BEATS)
                    chk_cycle($sformatf("R7 R8 mode%0d m3 t%0d", mode, t), 1 << 3, t - t3,
                              (t - t3 == LINE_BEATS - 1) ? 1 : 0);
                else if (t < t1b)
                    chk_cycle($sformatf("R6 mode%0d gap2 t%0d", mode, t), 0, 0, 0);
                else
                    chk_cycle($sformatf("R8 mode%0d m1 again t%0d", mode, t), 1 << 1, 0, 0);
            end
        end

        // R8: all masters request single beats; rotation starts at master 0.
        for (int mode = 0; mode < 2; mode++) begin
            do_reset(logic'(mode));
            req_kind = '0;
            req      = '1;
            for (int t = 0; t < 12; t++) begin
                @(negedge clk);
                if (mode == 1)
                    chk_cycle($sformatf("R8 stream t%0d", t), 1 << (t % N), 0, 1);
                else if (t % 2 == 0)
                    chk_cycle($sformatf("R8 spaced t%0d", t), 1 << ((t / 2) % N), 0, 1);
                else
                    chk_cycle($sformatf("R6 R8 spaced gap t%0d", t), 0, 0, 0);
            end
            req = '0;
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule